// File: doc/BRIEF.md
# Mixed-Page-Size Data Translation Buffer

This block is a fully associative translation cache for data accesses. By default it has 48 slots. Each slot maps a page of 4 KB, 2 MB or 1 GB, records that size, and holds a small set of permission bits. Pages of all three sizes can be resident at the same time.

A lookup offers a virtual address and gets its answer in the same cycle. The answer is a hit flag, the physical address, the page size and the permissions. Each slot compares the address only over the bits above its own page boundary.

When a valid lookup misses, the block raises a request for translation from a larger backing level. That level sends its answer back through a separate write port, and the new mapping is visible from the next cycle. Software or coherence logic can drop all mappings at once, or only the mappings that cover one given address.

Top module: `mpg_tlb`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses: `lk_hit`=0, `lk_multi`=0, `lk_paddr`=0, `lk_size`=0 and `lk_perm`=0.
- R2: Size codes are 0 for 4 KB, 1 for 2 MB and 2 for 1 GB. A slot compares virtual bits [47:12], [47:21] or [47:30] according to its own code, and a hit reports that code on `lk_size`.
- R3: On a hit, the physical address takes the slot's frame bits above the page boundary and the lookup's virtual bits below it. Frame bits the slot holds below the boundary are ignored.
- R4: On a hit, `lk_perm` returns the 3-bit permission value stored with the slot that answered.
- R5: A lookup is answered in the cycle it is presented. `lk_miss` is 1 exactly when `lk_valid` is 1 and no slot matches. With `lk_valid` at 0, `lk_hit`, `lk_miss` and `lk_multi` are all 0.
- R6: A refill with size code 0, 1 or 2 is written on the clock edge and answers lookups from the next cycle. A refill with size code 3 is discarded.
- R7: A refill goes into the lowest-numbered invalid slot when one exists.
- R8: When all slots are valid, a refill replaces the slot named by a rotating pointer. The pointer starts at slot 0 and advances by one, wrapping, only on refills of this kind.
- R9: If more than one slot matches a lookup, `lk_multi` is 1. The lowest-numbered matching slot supplies the physical address, the size and the permissions.
- R10: An invalidate-by-address clears, in one cycle, every slot whose size-masked tag matches the given address, and leaves all other slots valid.
- R11: Invalidate-all clears every slot in one cycle. A refill offered in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 48 | Lookup virtual address |
| lk_hit | output | 1 | Lookup found a mapping |
| lk_miss | output | 1 | Valid lookup found no mapping (refill request) |
| lk_multi | output | 1 | More than one slot matched (fault) |
| lk_paddr | output | 48 | Translated physical address |
| lk_size | output | 2 | Page size code of the matching slot |
| lk_perm | output | 3 | Permissions of the matching slot |
| fill_valid | input | 1 | Refill write strobe |
| fill_vpn | input | 36 | Refill virtual page number (virtual bits 47:12) |
| fill_ppn | input | 36 | Refill physical frame number (physical bits 47:12) |
| fill_size | input | 2 | Refill page size code |
| fill_perm | input | 3 | Refill permissions |
| inv_all | input | 1 | Clear all slots |
| inv_addr_valid | input | 1 | Clear slots that cover `inv_vaddr` |
| inv_vaddr | input | 48 | Address for invalidate-by-address |

## Verification
One mapping of each size is resident at once, and lookups are walked across each page. The lookups land at the base of each page, at offsets that set the highest bit below the boundary, and just outside the page on either side. These lookups show whether the compare mask is chosen per slot rather than globally, and whether the offset bits come from the virtual address.

The refills into the 2 MB slot carry nonzero junk bits below the page boundary, so a mask applied only to the tag, or only to the frame, is exposed. A small page placed inside the 1 GB page separates the lowest-index priority from a most-specific-match priority. It also shows that an address invalidate removes both overlapping mappings.

Filling every slot and then mixing refills with an address invalidate separates first-free placement from rotating replacement.

// File: rtl/mpg_tlb.sv
module mpg_tlb #(
  parameter int ENTRIES = 48,
  parameter int VA_W    = 48,
  parameter int PA_W    = 48,
  parameter int PERM_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_multi,
  output logic [PA_W-1:0]   lk_paddr,
  output logic [1:0]        lk_size,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              fill_valid,
  input  logic [VA_W-13:0]  fill_vpn,
  input  logic [PA_W-13:0]  fill_ppn,
  input  logic [1:0]        fill_size,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_all,
  input  logic              inv_addr_valid,
  input  logic [VA_W-1:0]   inv_vaddr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int VPN_W = VA_W - 12;
  localparam int PPN_W = PA_W - 12;

  function automatic logic [VPN_W-1:0] tag_mask(input logic [1:0] s);
    case (s)
      2'd1:    tag_mask = {VPN_W{1'b1}} << 9;
      2'd2:    tag_mask = {VPN_W{1'b1}} << 18;
      default: tag_mask = {VPN_W{1'b1}};
    endcase
  endfunction

  function automatic logic [PA_W-1:0] low_mask(input logic [1:0] s);
    case (s)
      2'd1:    low_mask = ~({PA_W{1'b1}} << 21);
      2'd2:    low_mask = ~({PA_W{1'b1}} << 30);
      default: low_mask = ~({PA_W{1'b1}} << 12);
    endcase
  endfunction

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag   [ENTRIES];
  logic [PPN_W-1:0]   frame [ENTRIES];
  logic [1:0]         psz   [ENTRIES];
  logic [PERM_W-1:0]  prm   [ENTRIES];
  logic [IDX_W-1:0]   rr;

  logic [ENTRIES-1:0] lk_match, inv_match;
  logic [VPN_W-1:0]   lk_vpn, inv_vpn;
  logic [IDX_W-1:0]   sel, free_idx, victim;
  logic               any_match, free_found, fill_ok;

  assign lk_vpn  = lk_vaddr[VA_W-1:12];
  assign inv_vpn = inv_vaddr[VA_W-1:12];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_match[i]  = vld[i] && (((lk_vpn  ^ tag[i]) & tag_mask(psz[i])) == '0);
    assign inv_match[i] = vld[i] && (((inv_vpn ^ tag[i]) & tag_mask(psz[i])) == '0);
  end

  always_comb begin
    sel = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) sel = IDX_W'(i);
      if (!vld[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_match  = |lk_match;
  assign free_found = ~&vld;
  assign victim     = free_found ? free_idx : rr;
  assign fill_ok    = fill_valid && (fill_size != 2'd3) && !inv_all;

  assign lk_hit   = lk_valid && any_match;
  assign lk_miss  = lk_valid && !any_match;
  assign lk_multi = lk_valid && ($countones(lk_match) > 1);
  assign lk_size  = lk_hit ? psz[sel] : 2'd0;
  assign lk_perm  = lk_hit ? prm[sel] : '0;
  assign lk_paddr = lk_hit ?
      (({frame[sel], 12'h000} & ~low_mask(psz[sel])) | (PA_W'(lk_vaddr) & low_mask(psz[sel])))
      : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      rr  <= '0;
    end else if (inv_all) begin
      vld <= '0;
    end else begin
      if (inv_addr_valid) vld <= vld & ~inv_match;
      if (fill_ok) begin
        vld[victim] <= 1'b1;
        if (!free_found) rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      tag[victim]   <= fill_vpn;
      frame[victim] <= fill_ppn;
      psz[victim]   <= fill_size;
      prm[victim]   <= fill_perm;
    end
  end
endmodule

// File: rtl/mpg_tlb_chk.sv
module mpg_tlb_chk #(
  parameter int VA_W = 48,
  parameter int PA_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_multi,
  input logic [PA_W-1:0]  lk_paddr,
  input logic [1:0]       lk_size,
  input logic             fill_valid,
  input logic [VA_W-13:0] fill_vpn,
  input logic [1:0]       fill_size,
  input logic             inv_all,
  input logic             inv_addr_valid
);
  logic             fill_d;
  logic [VA_W-13:0] vpn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_d <= 1'b0;
      vpn_d  <= '0;
    end else begin
      fill_d <= fill_valid && fill_size != 2'd3 && !inv_all && !inv_addr_valid;
      vpn_d  <= fill_vpn;
    end
  end

  a_r5_hit_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit || lk_miss) |-> lk_valid);
  a_r5_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));
  a_r9_multi_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit);
  a_r3_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[11:0] == lk_vaddr[11:0]);
  a_r2_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_size != 2'd3);
  a_r11_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !lk_hit);
  a_r6_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_d && lk_valid && lk_vaddr[VA_W-1:12] == vpn_d) |-> lk_hit);
endmodule

bind mpg_tlb mpg_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/mpg_tlb_bench.sv
`timescale 1ns/1ps
module mpg_tlb_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [47:0] lk_vaddr = '0;
  logic lk_hit, lk_miss, lk_multi;
  logic [47:0] lk_paddr;
  logic [1:0] lk_size;
  logic [2:0] lk_perm;
  logic fill_valid = 1'b0;
  logic [35:0] fill_vpn = '0, fill_ppn = '0;
  logic [1:0] fill_size = '0;
  logic [2:0] fill_perm = '0;
  logic inv_all = 1'b0, inv_addr_valid = 1'b0;
  logic [47:0] inv_vaddr = '0;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mpg_tlb u_mpg_tlb (.*);

  typedef struct packed {
    logic [47:0] va;
    logic        hit;
    logic [47:0] pa;
    logic [1:0]  size;
    logic [2:0]  perm;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{48'h0000_1234_5ABC, 1'b1, 48'h0000_ABCD_EABC, 2'd0, 3'b001},
    '{48'h0000_1234_6000, 1'b0, 48'h0, 2'd0, 3'b000},
    '{48'h0000_4030_1234, 1'b1, 48'h0000_8070_1234, 2'd1, 3'b011},
    '{48'h0000_403F_FFFF, 1'b1, 48'h0000_807F_FFFF, 2'd1, 3'b011},
    '{48'h0000_4040_0000, 1'b0, 48'h0, 2'd0, 3'b000},
    '{48'h0000_401F_FFFF, 1'b0, 48'h0, 2'd0, 3'b000},
    '{48'h0001_7ABC_DEF0, 1'b1, 48'h0002_FABC_DEF0, 2'd2, 3'b101},
    '{48'h0001_4000_0000, 1'b1, 48'h0002_C000_0000, 2'd2, 3'b101},
    '{48'h0001_8000_0000, 1'b0, 48'h0, 2'd0, 3'b000},
    '{48'h0001_3FFF_FFFF, 1'b0, 48'h0, 2'd0, 3'b000}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [35:0] vpn, input logic [35:0] ppn, input logic [1:0] sz, input logic [2:0] pm);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_size = sz; fill_perm = pm;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic inv_addr(input logic [47:0] va);
    @(negedge clk);
    inv_addr_valid = 1'b1; inv_vaddr = va;
    @(negedge clk);
    inv_addr_valid = 1'b0;
  endtask

  task automatic look(input logic [47:0] va);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va;
    #1;
  endtask

  task automatic expect_hit(input logic [47:0] va, input bit h, input string req);
    look(va);
    chk(lk_hit == h && lk_miss == !h, req, {62'd0, lk_hit, lk_miss}, {62'd0, h, !h});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    look(48'h0000_1234_5ABC);
    chk(!lk_hit && !lk_multi && lk_paddr == 0 && lk_size == 0 && lk_perm == 0,
        "R1 reset empty", {lk_hit, lk_multi, lk_size, lk_perm}, 0);
    chk(lk_miss, "R5 miss request", lk_miss, 1);

    fill(36'h0_0001_2345, 36'h0_0000_ABCDE, 2'd0, 3'b001);
    fill(36'h0_0004_03AB, 36'h0_0008_07FF, 2'd1, 3'b011);
    fill(36'h0_0014_0000, 36'h0_002C_0000, 2'd2, 3'b101);

    // R2 R3 R4 R5 table walk
    for (int i = 0; i < NV; i++) begin
      look(VEC[i].va);
      chk(lk_hit == VEC[i].hit && lk_miss == !VEC[i].hit, "R2 masked match", lk_hit, VEC[i].hit);
      if (VEC[i].hit) begin
        chk(lk_paddr == VEC[i].pa, "R3 paddr", lk_paddr, VEC[i].pa);
        chk(lk_size == VEC[i].size, "R2 size", lk_size, VEC[i].size);
        chk(lk_perm == VEC[i].perm, "R4 perm", lk_perm, VEC[i].perm);
      end
    end

    // R5 idle lookup
    @(negedge clk);
    lk_valid = 1'b0; lk_vaddr = 48'h0000_1234_5ABC;
    #1;
    chk(!lk_hit && !lk_miss && !lk_multi, "R5 idle", {lk_hit, lk_miss, lk_multi}, 0);

    // R9 overlapping mappings, slot 2 (1 GB) beats slot 3 (4 KB)
    fill(36'h0_0017_ABCD, 36'h0_0001_2345, 2'd0, 3'b111);
    look(48'h0001_7ABC_DEF0);
    chk(lk_multi, "R9 multi flag", lk_multi, 1);
    chk(lk_paddr == 48'h0002_FABC_DEF0 && lk_size == 2'd2 && lk_perm == 3'b101,
        "R9 lowest wins", lk_paddr, 48'h0002_FABC_DEF0);
    look(48'h0000_1234_5000);
    chk(!lk_multi, "R9 single no flag", lk_multi, 0);

    // R10 invalidate by address removes both overlapping slots only
    inv_addr(48'h0001_7ABC_D000);
    expect_hit(48'h0001_7ABC_DEF0, 1'b0, "R10 overlap cleared");
    expect_hit(48'h0001_4000_0000, 1'b0, "R10 large page cleared");
    expect_hit(48'h0000_4030_1234, 1'b1, "R10 other kept");
    expect_hit(48'h0000_1234_5ABC, 1'b1, "R10 other kept 4K");

    // R11 invalidate all beats a same-cycle refill
    @(negedge clk);
    inv_all = 1'b1; fill_valid = 1'b1; fill_vpn = 36'h0_0005_5555; fill_size = 2'd0;
    @(negedge clk);
    inv_all = 1'b0; fill_valid = 1'b0;
    expect_hit(48'h0000_1234_5ABC, 1'b0, "R11 cleared 4K");
    expect_hit(48'h0000_4030_1234, 1'b0, "R11 cleared 2M");
    expect_hit(48'h0005_5555_5000 >> 0 & 48'h0000_5555_5FFF, 1'b0, "R11 fill dropped");

    // R6 reserved size code is discarded
    fill(36'h0_0006_6666, 36'h0_0000_0001, 2'd3, 3'b111);
    expect_hit(48'h0000_6666_6000, 1'b0, "R6 size 3 dropped");

    // R7 R8 replacement
    for (int i = 0; i < 48; i++) fill(36'(i + 1), 36'(i + 256), 2'd0, 3'b010);
    for (int i = 0; i < 48; i++) begin
      look({36'(i + 1), 12'h010});
      chk(lk_hit && lk_paddr == {36'(i + 256), 12'h010}, "R6 R7 fill all",
          lk_paddr, {36'(i + 256), 12'h010});
    end
    fill(36'h900, 36'h1, 2'd0, 3'b010);
    expect_hit({36'd1, 12'h0}, 1'b0, "R8 slot0 replaced");
    expect_hit({36'd2, 12'h0}, 1'b1, "R8 slot1 kept");
    expect_hit({36'h900, 12'h0}, 1'b1, "R8 new present");
    fill(36'h901, 36'h2, 2'd0, 3'b010);
    expect_hit({36'd2, 12'h0}, 1'b0, "R8 pointer advanced");
    expect_hit({36'd3, 12'h0}, 1'b1, "R8 slot2 kept");
    inv_addr({36'd6, 12'h0});
    fill(36'h902, 36'h3, 2'd0, 3'b010);
    expect_hit({36'd3, 12'h0}, 1'b1, "R7 free slot preferred");
    expect_hit({36'h902, 12'h0}, 1'b1, "R7 new present");
    fill(36'h903, 36'h4, 2'd0, 3'b010);
    expect_hit({36'd3, 12'h0}, 1'b0, "R8 pointer resumes");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule